// File: doc/BRIEF.md
# Cross-Domain Microsecond Tick Generator

This block gives a serial bus controller a one-microsecond time base when the controller's own clock is not a whole number of megahertz. A fast clock, running at exactly twice the controller clock, is divided by a cycle count: 81 by default, which gives 1 MHz from 81 MHz. Each time the count expires, a single toggle bit flips. The fast clock domain is the only writer of that toggle bit.

The controller clock domain passes the toggle through a two-stage synchronizer. It compares the synchronized value with a history bit that only it writes. On a mismatch it raises `tick` for one controller cycle, then copies the synchronized value into the history bit. Nothing in the slow domain writes back into the fast domain.

A double-rate input halves the period, for delays that are scaled by two. Because the divide count is odd, double-rate mode alternates a short period (`DIV/2` cycles, 40) with a long one (`DIV - DIV/2` cycles, 41). Two half periods therefore add up to exactly one full period.

The fast divider is a state machine with three states:
- `PH_FULL`: a period of `DIV` cycles.
- `PH_SHORT`: a short half period.
- `PH_LONG`: a long half period.

State changes happen only at the terminal count, where the toggle flips:
- With `double_rate` low, every state goes to `PH_FULL`.
- With `double_rate` high, `PH_FULL` and `PH_LONG` go to `PH_SHORT`, and `PH_SHORT` goes to `PH_LONG`.

The edge detector in the slow domain has two states, `EDGE_IDLE` and `EDGE_PULSE`. It moves to `EDGE_PULSE` for the one cycle in which the synchronized toggle differs from the history bit. It then returns to `EDGE_IDLE`.

Top module: `usec_tick_gen`

## Requirements
- R1: While `rst_fast` and `rst_slow` are high, `tick` is low and the cycle counter, toggle, synchronizer and history bit are zero. After release, timing restarts from a fresh `PH_FULL` period.
- R2: With `double_rate` low, the toggle flips every `DIV` fast cycles. Any window of 20·`DIV`/2 slow cycles (810 by default) therefore holds exactly 20 ticks.
- R3: Each toggle transition produces exactly one `tick` pulse, and that pulse is one slow cycle wide.
- R4: In double-rate mode the periods alternate `DIV/2` and `DIV-DIV/2` fast cycles. The first period after a switch from `PH_FULL` is the short one.
- R5: A change of `double_rate` takes effect only at a terminal count. The period already running completes at its original length.
- R6: In steady double-rate mode, an 810-slow-cycle window holds exactly 40 ticks, with no drift from the odd count.
- R7: `tick` is high during the slow cycle after the second slow rising edge at which the new toggle value is present at the synchronizer input.
- R8: The toggle changes only at the fast divider's terminal count. The slow domain never writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, twice the controller rate |
| rst_fast | input | 1 | Synchronous reset, fast domain, active high |
| double_rate | input | 1 | 1 selects half-length periods; fast domain, quasi-static |
| clk_slow | input | 1 | Controller clock |
| rst_slow | input | 1 | Synchronous reset, slow domain, active high |
| tick | output | 1 | One-cycle pulse per microsecond (per half microsecond in double-rate mode), slow domain |

## Verification
The two functions that can fall in the same fast cycle are the terminal count and a change of `double_rate`. On that cycle the divider must choose the next state from the new mode value while closing the old period at its old length. The bench provokes this by sweeping the instant of the mode change across every offset of a period, in both directions. A behavioural model of the period sequence and of the synchronizer delay predicts `tick` on every slow cycle. Steady-state tick counts over fixed windows judge the long-run rate in each mode.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;
    typedef enum logic [1:0] {
        PH_FULL  = 2'd0,
        PH_SHORT = 2'd1,
        PH_LONG  = 2'd2
    } phase_t;

    typedef enum logic {
        EDGE_IDLE  = 1'b0,
        EDGE_PULSE = 1'b1
    } edge_t;
endpackage

// File: rtl/usec_fast_divider.sv
module usec_fast_divider
    import usec_tick_pkg::*;
#(
    parameter int DIV = 81
) (
    input  logic clk,
    input  logic rst,
    input  logic double_rate,
    output logic toggle_o
);
    localparam int LEN_SHORT = DIV / 2;
    localparam int LEN_LONG  = DIV - LEN_SHORT;
    localparam int CW        = $clog2(DIV + 1);

    phase_t        phase_q, phase_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;
    logic          at_end;
    logic          toggle_q;

    // Output process: period length of the current state
    always_comb begin
        unique case (phase_q)
            PH_FULL:  last_cnt = CW'(DIV - 1);
            PH_SHORT: last_cnt = CW'(LEN_SHORT - 1);
            PH_LONG:  last_cnt = CW'(LEN_LONG - 1);
            default:  last_cnt = CW'(DIV - 1);
        endcase
    end

    assign at_end = (cnt_q == last_cnt);

    // Next-state choice at the terminal count
    always_comb begin
        phase_d = phase_q;
        if (at_end) begin
            if (!double_rate) begin
                phase_d = PH_FULL;
            end else begin
                unique case (phase_q)
                    PH_FULL:  phase_d = PH_SHORT;
                    PH_SHORT: phase_d = PH_LONG;
                    PH_LONG:  phase_d = PH_SHORT;
                    default:  phase_d = PH_SHORT;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_FULL;
        else     phase_q <= phase_d;
    end

    // Counter and toggle, owned by this domain only
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            toggle_q <= 1'b0;
        end else if (at_end) begin
            cnt_q    <= '0;
            toggle_q <= ~toggle_q;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

    assign toggle_o = toggle_q;

    // R8
    tog_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        (toggle_q != $past(toggle_q)) |-> $past(at_end));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DIV - 1));

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> $stable(phase_q));
endmodule

// File: rtl/usec_sync.sv
module usec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/usec_edge_detect.sv
module usec_edge_detect
    import usec_tick_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic tick_o
);
    logic  hist_q;
    edge_t st;

    // Classification of the current cycle
    always_comb begin
        st = (level_i != hist_q) ? EDGE_PULSE : EDGE_IDLE;
    end

    // History register: written only here, from the synchronized level
    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= level_i;
    end

    // Output process
    always_comb begin
        unique case (st)
            EDGE_PULSE: tick_o = 1'b1;
            EDGE_IDLE:  tick_o = 1'b0;
            default:    tick_o = 1'b0;
        endcase
    end

    // R3
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !tick_o);
endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen #(
    parameter int DIV         = 81,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_fast,
    input  logic rst_fast,
    input  logic double_rate,
    input  logic clk_slow,
    input  logic rst_slow,
    output logic tick
);
    logic toggle_fast;
    logic toggle_sync;

    usec_fast_divider #(.DIV(DIV)) u_div (
        .clk         (clk_fast),
        .rst         (rst_fast),
        .double_rate (double_rate),
        .toggle_o    (toggle_fast)
    );

    usec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk_slow),
        .rst (rst_slow),
        .d   (toggle_fast),
        .q   (toggle_sync)
    );

    usec_edge_detect u_edge (
        .clk     (clk_slow),
        .rst     (rst_slow),
        .level_i (toggle_sync),
        .tick_o  (tick)
    );
endmodule

// File: tb/usec_tick_gen_test.sv
module usec_tick_gen_test;
    localparam int DIV = 81;

    logic clk_fast = 1'b0;
    logic clk_slow = 1'b0;
    logic rst_fast = 1'b1;
    logic rst_slow = 1'b1;
    logic double_rate = 1'b0;
    logic tick;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // 125 MHz fast clock; slow clock at half rate, edges offset from the fast ones
    always #4 clk_fast = ~clk_fast;
    always #8 clk_slow = ~clk_slow;

    usec_tick_gen #(.DIV(DIV)) uut (
        .clk_fast    (clk_fast),
        .rst_fast    (rst_fast),
        .double_rate (double_rate),
        .clk_slow    (clk_slow),
        .rst_slow    (rst_slow),
        .tick        (tick)
    );

    // Behavioural model, fast side: elapsed cycles and expected toggle
    int m_elapsed = 0;
    int m_len = DIV;
    bit m_tog = 1'b0;
    bit m_next_short = 1'b1;

    always @(posedge clk_fast) begin
        if (rst_fast) begin
            m_elapsed = 0;
            m_len = DIV;
            m_tog = 1'b0;
            m_next_short = 1'b1;
        end else begin
            m_elapsed = m_elapsed + 1;
            if (m_elapsed == m_len) begin
                m_elapsed = 0;
                m_tog = ~m_tog;
                if (double_rate) begin
                    m_len = m_next_short ? DIV / 2 : DIV - DIV / 2;
                    m_next_short = ~m_next_short;
                end else begin
                    m_len = DIV;
                    m_next_short = 1'b1;
                end
            end
        end
    end

    // Model, slow side: a queue of sampled toggle values
    bit samp[$];

    always @(posedge clk_slow) begin
        if (rst_slow) begin
            samp = '{1'b0, 1'b0, 1'b0};
        end else begin
            samp.push_front(m_tog);
            void'(samp.pop_back());
        end
    end

    bit counting = 1'b0;
    int win_ticks = 0;

    // Compare on every slow cycle, away from the rising edge
    always @(negedge clk_slow) begin
        if (samp.size() == 3) begin
            bit exp_tick;
            exp_tick = samp[1] ^ samp[2];
            checks++;
            if (tick !== exp_tick) begin
                failures++;
                $display("FAIL R2 R3 R4 R5 R7 t=%0t tick actual=%b expected=%b",
                         $time, tick, exp_tick);
            end
        end
        if (counting && tick === 1'b1) win_ticks++;
    end

    task automatic slow_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_slow);
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic window(input string req, input int exp);
        win_ticks = 0;
        counting = 1'b1;
        slow_cycles(810);
        counting = 1'b0;
        check_eq(req, win_ticks, exp);
    endtask

    // Watchdog
    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk_fast);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        slow_cycles(6);
        // R1: reset state
        check_eq("R1 tick in reset", int'(tick), 0);
        @(negedge clk_fast);
        rst_fast = 1'b0;
        rst_slow = 1'b0;
        slow_cycles(100);
        window("R2 normal-mode window", 20);

        double_rate = 1'b1;
        slow_cycles(100);
        window("R6 double-rate window", 40);

        // R5 / R4: sweep the mode change across every offset of a period
        for (int off = 0; off < 46; off++) begin
            @(negedge clk_fast);
            double_rate = 1'b0;
            for (int k = 0; k < off + 90; k++) @(negedge clk_fast);
            double_rate = 1'b1;
            for (int k = 0; k < off + 50; k++) @(negedge clk_fast);
        end

        double_rate = 1'b0;
        slow_cycles(100);
        window("R2 normal-mode window after sweep", 20);

        // R1: reset in the middle of a run
        slow_cycles(17);
        @(negedge clk_fast);
        rst_fast = 1'b1;
        rst_slow = 1'b1;
        slow_cycles(5);
        check_eq("R1 tick during mid-run reset", int'(tick), 0);
        @(negedge clk_fast);
        rst_fast = 1'b0;
        rst_slow = 1'b0;
        slow_cycles(300);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule